// File: doc/BRIEF.md
# Single-Class Repetition Matcher

This block is one state of a bit-parallel regular-expression engine. It handles a bounded run of one character or one character class. The preceding state delivers a token bit. A character decoder elsewhere delivers a match bit, one per input character. The block reports a token at its output once that token has been followed through a run of `DEPTH` consecutive matching characters. The character on which the token arrives counts as the first of these.

Every token in flight is tracked separately in a chain of `DEPTH` flops. Tokens may therefore enter on back-to-back characters, and each one produces its own report, so overlapping matches are all seen. The parameter `MODE` selects one of two variants. `REP_EXACT` implements `x{DEPTH}` and gives one output cycle per token. `REP_ATLEAST` implements `x{DEPTH,}`, and its output stays high for as long as the run of matching characters continues. A cycle with the enable low is not a character, so all state holds. A valid non-matching character empties the whole block.

Top module: `rep_match_core`

## Requirements
- R1: A token presented with `chr_valid`=1 and `chr_hit`=1 appears on `tok_out` right after the clock edge of the `DEPTH`-th consecutive valid matching character, counting the arrival character as the first.
- R2: Tokens entering on consecutive valid matching characters are each reported, on consecutive valid characters, so overlapping matches are not lost.
- R3: In `REP_EXACT` mode a token is reported for exactly one valid character. It leaves the chain on the next valid character.
- R4: In `REP_ATLEAST` mode, once `tok_out` is high it stays high after every further valid matching character.
- R5: A valid character with `chr_hit`=0 clears every in-flight token and, in `REP_ATLEAST` mode, the held output. `tok_out` is 0 after that edge.
- R6: A token presented on a valid character with `chr_hit`=0 is dropped and never reaches `tok_out`.
- R7: While `chr_valid`=0, all state and `tok_out` hold their values whatever `tok_in` and `chr_hit` do.
- R8: A synchronous `rst`=1 clears all state, and `tok_out` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chr_valid | input | 1 | A character is present this cycle |
| tok_in | input | 1 | Token from the preceding NFA state |
| chr_hit | input | 1 | The current character is in the repeated class |
| tok_out | output | 1 | Token to the following NFA state |

## Verification
A token's report is due after the edge of its `DEPTH`-th valid matching character. A flush, a hold or a reset takes effect after the very next edge. The bench drives inputs on the falling edge and advances its age-list model at that point, ahead of the rising edge that will consume them. It compares both outputs on the following falling edge, so every expectation lands exactly one edge after the stimulus it depends on. Directed runs place reports at the exact depth, overlap tokens, and insert stalls and mismatches. A long biased random run then covers mixed cases.

// File: rtl/rep_pkg.sv
package rep_pkg;
  typedef enum logic [0:0] {
    REP_EXACT   = 1'b0,
    REP_ATLEAST = 1'b1
  } rep_mode_e;
endpackage

// File: rtl/rep_token_shift.sv
module rep_token_shift #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             flush,
  input  logic             tok_in,
  output logic [DEPTH-1:0] stages
);
  // advance every in-flight token by one matched character
  function automatic logic [DEPTH-1:0] advance(input logic [DEPTH-1:0] cur, input logic fresh);
    logic [DEPTH-1:0] nxt;
    nxt = cur << 1;
    nxt[0] = fresh;
    return nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) stages <= '0;
    else if (step)    stages <= advance(stages, tok_in);
  end

  // R5
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (stages == '0));
  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !flush) |=> $stable(stages));
  // R1
  entry_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (stages[0] == $past(tok_in)));
endmodule

// File: rtl/rep_tail_hold.sv
module rep_tail_hold
  import rep_pkg::*;
#(
  parameter rep_mode_e MODE = REP_EXACT
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic flush,
  input  logic last_stage,
  output logic tok_out
);
  generate
    if (MODE == REP_ATLEAST) begin : g_hold
      logic held;
      always_ff @(posedge clk) begin
        if (rst || flush) held <= 1'b0;
        else if (step)    held <= held | last_stage;
      end
      assign tok_out = last_stage | held;

      // R4
      run_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (step && tok_out) |=> tok_out);
      // R5
      miss_drops_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !tok_out);
    end else begin : g_exact
      assign tok_out = last_stage;

      // R7
      exact_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !flush) |=> (tok_out == $past(tok_out)));
      // R5
      exact_miss_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !tok_out);
    end
  endgenerate
endmodule

// File: rtl/rep_match_core.sv
module rep_match_core
  import rep_pkg::*;
#(
  parameter int        DEPTH = 4,
  parameter rep_mode_e MODE  = REP_EXACT
) (
  input  logic clk,
  input  logic rst,
  input  logic chr_valid,
  input  logic tok_in,
  input  logic chr_hit,
  output logic tok_out
);
  localparam int LAST = DEPTH - 1;

  logic             step_evt;
  logic             flush_evt;
  logic [DEPTH-1:0] chain;

  assign step_evt  = chr_valid & chr_hit;
  assign flush_evt = chr_valid & ~chr_hit;

  rep_token_shift #(.DEPTH(DEPTH)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .step   (step_evt),
    .flush  (flush_evt),
    .tok_in (tok_in),
    .stages (chain)
  );

  rep_tail_hold #(.MODE(MODE)) u_tail (
    .clk        (clk),
    .rst        (rst),
    .step       (step_evt),
    .flush      (flush_evt),
    .last_stage (chain[LAST]),
    .tok_out    (tok_out)
  );

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !tok_out);

  initial begin
    assert (DEPTH >= 1) else $error("DEPTH must be at least 1");
  end
endmodule

// File: tb/rep_match_core_tb_top.sv
module rep_match_core_tb_top;
  import rep_pkg::*;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chr_valid = 1'b0;
  logic tok_in = 1'b0;
  logic chr_hit = 1'b0;
  logic out_ex, out_al;

  int checks = 0;
  int fails = 0;
  int ages[$];
  bit held_m = 1'b0;

  always #4 clk = ~clk;

  rep_match_core #(.DEPTH(N), .MODE(REP_EXACT)) dut_i (
    .clk(clk), .rst(rst), .chr_valid(chr_valid), .tok_in(tok_in),
    .chr_hit(chr_hit), .tok_out(out_ex));

  rep_match_core #(.DEPTH(N), .MODE(REP_ATLEAST)) dut_al_i (
    .clk(clk), .rst(rst), .chr_valid(chr_valid), .tok_in(tok_in),
    .chr_hit(chr_hit), .tok_out(out_al));

  function automatic bit any_full();
    foreach (ages[k]) if (ages[k] == N) return 1'b1;
    return 1'b0;
  endfunction

  // behavioural model: list of ages (matched characters) per live token
  task automatic model_step(input bit v, input bit t, input bit h);
    int nxt[$];
    if (!v) return;
    if (!h) begin
      ages.delete();
      held_m = 1'b0;
      return;
    end
    held_m = held_m | any_full();
    foreach (ages[k]) if (ages[k] + 1 <= N) nxt.push_back(ages[k] + 1);
    if (t) nxt.push_back(1);
    ages = nxt;
  endtask

  task automatic check(input string req);
    bit ex_e, al_e;
    ex_e = any_full();
    al_e = ex_e | held_m;
    checks++;
    if (out_ex !== ex_e) begin
      fails++;
      $display("FAIL %s exact: got %b expected %b at %0t", req, out_ex, ex_e, $time);
    end
    checks++;
    if (out_al !== al_e) begin
      fails++;
      $display("FAIL %s atleast: got %b expected %b at %0t", req, out_al, al_e, $time);
    end
  endtask

  // drive one character, then check after the consuming edge
  task automatic drive(input bit v, input bit t, input bit h, input string req);
    chr_valid = v; tok_in = t; chr_hit = h;
    model_step(v, t, h);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8");
    rst = 1'b0;
    // R1: single token reaches output after N hits
    drive(1, 1, 1, "R1");
    for (int i = 0; i < N - 1; i++) drive(1, 0, 1, "R1");
    // R3 / R4: further hits
    for (int i = 0; i < 3; i++) drive(1, 0, 1, "R3_R4");
    // R5: mismatch clears
    drive(1, 0, 0, "R5");
    // R2: overlapping tokens
    for (int i = 0; i < 3; i++) drive(1, 1, 1, "R2");
    for (int i = 0; i < N + 1; i++) drive(1, 0, 1, "R2");
    drive(1, 0, 0, "R5");
    // R6: token on a miss is dropped
    drive(1, 1, 0, "R6");
    for (int i = 0; i < N + 1; i++) drive(1, 0, 1, "R6");
    // R7: stalls in the middle of a run
    drive(1, 1, 1, "R7");
    for (int i = 0; i < N + 2; i++) begin
      drive(0, 1, 0, "R7");
      drive(1, 0, 1, "R7");
    end
    // R8: reset mid-run
    drive(1, 1, 1, "R8");
    for (int i = 0; i < N; i++) drive(1, 0, 1, "R8");
    rst = 1'b1;
    ages.delete();
    held_m = 1'b0;
    @(negedge clk);
    check("R8");
    rst = 1'b0;
    // mixed random traffic
    for (int i = 0; i < 4000; i++)
      drive(($urandom % 8) != 0, ($urandom % 3) == 0, ($urandom % 10) != 0, "R1_R2_R3_R4_R5_R7");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule